// File: doc/BRIEF.md
# Handshake Bus Register Slave

This block is the target end of an asynchronous, fully interlocked two-wire bus. The bus has an 18-bit byte address and a 16-bit data path. A master presents an address, a two-bit cycle type, write data and its own small identifier. It then raises a master strobe. The slave brings that strobe into its own clock domain through a two-flop synchronizer and latches the bus lines. It decodes whether it is the target and carries out the access on a small bank of word registers. It then raises its acknowledge strobe and holds it until the master strobe falls. An unaddressed slave never acknowledges, so the master's own timeout handles the miss.

The registers sit at the bottom of the peripheral window, which is the top 8 kB of the space (A17..A13 all ones). Register `i` is at window base + 2·i. A read-with-pause cycle returns data like a plain read and also reserves that register for the master that issued it. Until the same master writes that register, or the bus init line is pulsed, writes to it from any other master are acknowledged but discarded. Byte writes update one lane, chosen by address bit 0.

The controller is a five-state machine:
- IDLE: waits for the synchronized strobe and latches the bus lines → DECODE.
- DECODE: a hit → ACCESS; a miss → SKIP.
- ACCESS: performs the write or registers the read data → ACK.
- ACK: drives the acknowledge; when the synchronized strobe is low → IDLE.
- SKIP: stays silent; when the synchronized strobe is low → IDLE.

Bus init returns the machine to IDLE from any state.

Top module: `async_bus_slave`

## Requirements
- R1: After reset, or in the cycle after `bus_init` is high, all registers read 0, no register is reserved, and `ssync` and `rdata_oe` are low.
- R2: `cyc` encodes the cycle as 00 read, 01 read-with-pause, 10 word write, 11 byte write. Only 01 creates a reservation.
- R3: A cycle is claimed only when addr[17:13] are all ones and addr[12:4] are zero (with 8 registers). Any other address gets no `ssync` and changes no register.
- R4: `ssync` rises no earlier than the fourth clock after `msync` rises. It rises only once the write has been applied or the read data is on `rdata`. `rdata_oe` is high with `ssync` for read cycles only.
- R5: Once raised, `ssync` stays high while `msync` is high and falls within a few clocks after `msync` falls.
- R6: A word write stores all 16 bits into register addr[3:1]. addr[0] is ignored.
- R7: A byte write with addr[0]=0 updates bits 7:0 only. With addr[0]=1 it updates bits 15:8 only. The other byte keeps its value.
- R8: While a register is reserved by master M, word or byte writes to it from a different `mid` are acknowledged but leave it unchanged. Reads and writes to other registers are unaffected.
- R9: A word or byte write from M to its reserved register takes effect and ends the reservation.
- R10: `bus_init` cancels any reservation, after which any master may write the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_init | input | 1 | Synchronous bus initialise: clears registers and reservation |
| msync | input | 1 | Master strobe, asynchronous |
| addr | input | 18 | Byte address |
| cyc | input | 2 | Cycle type |
| wdata | input | 16 | Write data |
| mid | input | 2 | Identifier of the requesting master |
| ssync | output | 1 | Slave acknowledge strobe |
| rdata | output | 16 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data valid / drive enable |

## Verification
The hardest state to reach is a reserved register being hit by a second master. It needs a read-with-pause from one identifier, then writes from another identifier that complete the full handshake, then the owner's completing write. The stimulus plays that sequence with word and byte writes, and confirms that a write to a neighbouring register still lands. The same reservation is then set up again and cut off by `bus_init` rather than by a write. Every register is also swept with word and byte patterns, and with addresses just outside the window, and then read back against a model computed in the bench.

// File: rtl/asb_pkg.sv
package asb_pkg;
    typedef enum logic [1:0] {
        CYC_RD   = 2'b00,
        CYC_RDP  = 2'b01,
        CYC_WR   = 2'b10,
        CYC_WRB  = 2'b11
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACCESS,
        ST_ACK,
        ST_SKIP
    } st_e;
endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/asb_decode.sv
module asb_decode
    import asb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int WIN_W  = 13,
    parameter int NREGS  = 8,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cyc,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              is_write,
    output logic              is_byte,
    output logic              is_pause,
    output logic              lane_hi
);
    logic in_window;
    logic in_bank;

    always_comb begin
        in_window = &addr[ADDR_W-1:WIN_W];
        in_bank   = (addr[WIN_W-1:IDX_W+1] == '0);
        hit       = in_window && in_bank;
        idx       = addr[IDX_W:1];
        lane_hi   = addr[0];
        is_write  = (cyc == CYC_WR) || (cyc == CYC_WRB);
        is_byte   = (cyc == CYC_WRB);
        is_pause  = (cyc == CYC_RDP);
    end
endmodule

// File: rtl/asb_regbank.sv
module asb_regbank #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 8,
    parameter int ID_W   = 2,
    localparam int IDX_W  = $clog2(NREGS),
    localparam int LANE_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              acc_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic              is_write,
    input  logic              is_byte,
    input  logic              is_pause,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ID_W-1:0]   mid,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] mem [NREGS];
    logic              lk_v;
    logic [IDX_W-1:0]  lk_i;
    logic [ID_W-1:0]   lk_o;
    logic              blocked;
    logic              wr_do;
    logic [1:0]        be;

    always_comb begin
        blocked = lk_v && (idx == lk_i) && (mid != lk_o);
        wr_do   = acc_en && is_write && !blocked;
        be      = is_byte ? (lane_hi ? 2'b10 : 2'b01) : 2'b11;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= '0;
        end else if (wr_do) begin
            if (be[0]) mem[idx][LANE_W-1:0]      <= wdata[LANE_W-1:0];
            if (be[1]) mem[idx][DATA_W-1:LANE_W] <= wdata[DATA_W-1:LANE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_v <= 1'b0;
            lk_i <= '0;
            lk_o <= '0;
        end else if (clr) begin
            lk_v <= 1'b0;
        end else if (acc_en && is_pause && (!lk_v || mid == lk_o)) begin
            lk_v <= 1'b1;
            lk_i <= idx;
            lk_o <= mid;
        end else if (wr_do && lk_v && idx == lk_i) begin
            lk_v <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rdata_q <= '0;
        else if (clr)                  rdata_q <= '0;
        else if (acc_en && !is_write)  rdata_q <= mem[idx];
    end

    AST_LOCK_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && is_write && blocked && !clr) |=> (mem[$past(idx)] == $past(mem[idx]))); // R8

    AST_BYTE_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && is_write && is_byte && !lane_hi && !clr)
        |=> (mem[$past(idx)][DATA_W-1:LANE_W] == $past(mem[idx][DATA_W-1:LANE_W]))); // R7

    AST_BYTE_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && is_write && is_byte && lane_hi && !clr)
        |=> (mem[$past(idx)][LANE_W-1:0] == $past(mem[idx][LANE_W-1:0]))); // R7

    AST_INIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !lk_v); // R10
endmodule

// File: rtl/async_bus_slave.sv
module async_bus_slave
    import asb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 13,
    parameter int NREGS  = 8,
    parameter int ID_W   = 2,
    localparam int IDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_init,
    input  logic              msync,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cyc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ID_W-1:0]   mid,
    output logic              ssync,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    st_e               state, nxt;
    logic              msync_s;
    logic [ADDR_W-1:0] a_q;
    logic [1:0]        c_q;
    logic [DATA_W-1:0] d_q;
    logic [ID_W-1:0]   id_q;
    logic              hit, is_write, is_byte, is_pause, lane_hi;
    logic [IDX_W-1:0]  idx;
    logic              acc_en;
    logic [DATA_W-1:0] rd_q;

    asb_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(msync), .q(msync_s)
    );

    asb_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W), .NREGS(NREGS)) u_dec (
        .addr(a_q), .cyc(c_q), .hit(hit), .idx(idx), .is_write(is_write),
        .is_byte(is_byte), .is_pause(is_pause), .lane_hi(lane_hi)
    );

    asb_regbank #(.DATA_W(DATA_W), .NREGS(NREGS), .ID_W(ID_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(bus_init), .acc_en(acc_en), .idx(idx),
        .is_write(is_write), .is_byte(is_byte), .is_pause(is_pause),
        .lane_hi(lane_hi), .wdata(d_q), .mid(id_q), .rdata_q(rd_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_IDLE;
        else if (bus_init) state <= ST_IDLE;
        else               state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (msync_s) nxt = ST_DECODE;
            ST_DECODE: nxt = hit ? ST_ACCESS : ST_SKIP;
            ST_ACCESS: nxt = ST_ACK;
            ST_ACK:    if (!msync_s) nxt = ST_IDLE;
            ST_SKIP:   if (!msync_s) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q  <= '0;
            c_q  <= '0;
            d_q  <= '0;
            id_q <= '0;
        end else if (state == ST_IDLE && msync_s) begin
            a_q  <= addr;
            c_q  <= cyc;
            d_q  <= wdata;
            id_q <= mid;
        end
    end

    always_comb begin
        acc_en   = (state == ST_ACCESS);
        ssync    = (state == ST_ACK);
        rdata_oe = ssync && !is_write;
        rdata    = rdata_oe ? rd_q : '0;
    end

    AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ssync && msync_s && !bus_init) |=> ssync); // R5

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ssync && !msync_s) |=> !ssync); // R5

    AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ssync) |-> msync_s); // R4

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && !hit) |=> !ssync); // R3
endmodule

// File: tb/async_bus_slave_tb.sv
module async_bus_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NREGS = 8;
    localparam logic [17:0] BASE = 18'h3E000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_init = 1'b0;
    logic        msync = 1'b0;
    logic [17:0] addr = '0;
    logic [1:0]  cyc = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  mid = '0;
    logic        ssync;
    logic [15:0] rdata;
    logic        rdata_oe;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] model [NREGS];
    bit          lk_v = 0;
    int          lk_i = 0;
    logic [1:0]  lk_o = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_bus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_init(bus_init), .msync(msync),
        .addr(addr), .cyc(cyc), .wdata(wdata), .mid(mid),
        .ssync(ssync), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic [17:0] a, input logic [1:0] c,
                          input logic [15:0] d, input logic [1:0] id,
                          output bit ack, output logic [15:0] rd);
        int n;
        ack = 0;
        rd = '0;
        @(negedge clk);
        addr = a; cyc = c; wdata = d; mid = id; msync = 1'b1;
        n = 0;
        while (!ack && n < 12) begin
            @(negedge clk);
            n++;
            if (ssync) ack = 1;
        end
        if (ack) begin
            check(n >= 4, "R4", "ssync latency", n, 4);
            check(rdata_oe == !c[1], "R4", "rdata_oe with ssync", rdata_oe, !c[1]);
            rd = rdata;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(ssync == 1'b1, "R5", "ssync held", ssync, 1);
            end
        end
        msync = 1'b0;
        n = 0;
        while (ssync && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(ssync == 1'b0, "R5", "ssync released", ssync, 0);
        repeat (4) @(negedge clk);
    endtask

    function automatic bit may_write(input int i, input logic [1:0] id);
        return !(lk_v && lk_i == i && lk_o != id);
    endfunction

    task automatic do_write(input int i, input bit byt, input bit hi,
                            input logic [15:0] d, input logic [1:0] id, input string req);
        bit ack;
        logic [15:0] rd;
        bus_op(BASE + 18'(2*i) + 18'(hi), byt ? 2'b11 : 2'b10, d, id, ack, rd);
        check(ack, req, "write acknowledged", ack, 1);
        if (may_write(i, id)) begin
            if (!byt)    model[i] = d;
            else if (hi) model[i][15:8] = d[15:8];
            else         model[i][7:0] = d[7:0];
            if (lk_v && lk_i == i) lk_v = 0;
        end
    endtask

    task automatic do_read(input int i, input bit pause, input logic [1:0] id, input string req);
        bit ack;
        logic [15:0] rd;
        bus_op(BASE + 18'(2*i), pause ? 2'b01 : 2'b00, 16'hFFFF, id, ack, rd);
        check(ack, req, "read acknowledged", ack, 1);
        check(rd == model[i], req, $sformatf("read reg %0d", i), rd, model[i]);
        if (pause && (!lk_v || lk_o == id)) begin
            lk_v = 1; lk_i = i; lk_o = id;
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NREGS; i++) do_read(i, 0, 2'd0, req);
    endtask

    task automatic miss(input logic [17:0] a);
        bit ack;
        logic [15:0] rd;
        bus_op(a, 2'b10, 16'hDEAD, 2'd0, ack, rd);
        check(!ack, "R3", $sformatf("no ack at %0h", a), ack, 0);
    endtask

    task automatic pulse_init();
        @(negedge clk);
        bus_init = 1'b1;
        @(negedge clk);
        bus_init = 1'b0;
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        lk_v = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ssync == 0 && rdata_oe == 0, "R1", "idle strobes after reset", {ssync, rdata_oe}, 0);
        read_all("R1");

        // R6: word write sweep, addr[0] toggled and ignored
        for (int i = 0; i < NREGS; i++) begin
            bit ack;
            logic [15:0] rd;
            logic [15:0] d = 16'hA5C3 ^ 16'(i * 16'h1111);
            bus_op(BASE + 18'(2*i) + 18'(i & 1), 2'b10, d, 2'd0, ack, rd);
            check(ack, "R6", "word write ack", ack, 1);
            model[i] = d;
        end
        read_all("R6");

        // R7: byte lanes
        for (int i = 0; i < NREGS; i++) begin
            do_write(i, 1, 0, 16'h7700 | 16'(i * 3), 2'd0, "R7");
            do_write(i, 1, 1, 16'h0066 | 16'(i << 12), 2'd0, "R7");
        end
        read_all("R7");

        // R3: outside window or beyond the bank
        for (int i = 0; i < 4; i++) miss(18'h1E000 + 18'(2*i));
        miss(18'h00000);
        miss(18'h3DFFE);
        miss(BASE + 18'(2*NREGS));
        miss(BASE + 18'h1000);
        read_all("R3");

        // R2: plain read does not reserve
        do_read(6, 0, 2'd1, "R2");
        do_write(6, 0, 0, 16'h1234, 2'd2, "R2");
        do_read(6, 0, 2'd0, "R2");

        // R8: reservation blocks other masters
        do_read(3, 1, 2'd1, "R8");
        do_write(3, 0, 0, 16'hBAD0, 2'd2, "R8");
        do_write(3, 1, 1, 16'hBB00, 2'd2, "R8");
        do_read(3, 0, 2'd2, "R8");
        do_write(4, 0, 0, 16'h4444, 2'd2, "R8");
        do_read(4, 0, 2'd0, "R8");

        // R9: owner's byte write completes and releases
        do_write(3, 1, 0, 16'h005A, 2'd1, "R9");
        do_read(3, 0, 2'd0, "R9");
        do_write(3, 0, 0, 16'hC0DE, 2'd2, "R9");
        do_read(3, 0, 2'd0, "R9");

        // R10 and R1: init cancels reservation and clears registers
        do_read(5, 1, 2'd1, "R10");
        pulse_init();
        check(ssync == 0, "R1", "ssync low after init", ssync, 0);
        read_all("R1");
        do_write(5, 0, 0, 16'h5A5A, 2'd2, "R10");
        do_read(5, 0, 2'd3, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule